// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small 8-bit accumulator processor that uses 16-bit instructions. It does not decode instructions through gates. A register holds one 30-bit microword, and that word drives every control line of the datapath: register enables and clears, multiplexer selects, the ALU function, the ALU carry-in and the memory write strobe. The register loads a new microword on every clock edge. A 256-entry microstore supplies that word, and a 16-entry dispatch table turns the 4-bit opcode into the first micro-address of that opcode's routine.

The next micro-address comes from one of three sources, in priority order:
1. In the decode phase, the dispatch table output.
2. On a conditional microword whose condition holds, a forced return to the fetch word. This skips the PC increment.
3. Otherwise, the link field of the current microword.

The surrounding datapath provides the upper six instruction-register bits and the carry and zero flags. It consumes the control lines.

There is no data stream through this block. All of its pins are plain control and status pins, so there is no valid/ready handshake and no back-pressure.

Top module: `ucode_sequencer`

## Requirements
- R1: While reset is low the microword register is all zeros, so every control output is low and `phase` reads 00. The first rising edge after reset is released loads the fetch word: `ir_en`=1, `phase`=00.
- R2: Phase codes are 00 fetch, 01 decode, 10 execute and 11 increment. The fetch word sits at 0x00 and links to the decode word at 0x01. The increment word sits at 0x02 (`pc_en`=1, `opa_sel`=1, carry mode 01) and links to 0x00.
- R3: In the decode phase the next address is the dispatch entry for `ir_opcode`. The entries are: 0→0x10 load-immediate, 1→0x1C and, 2→0x1D xor, 4→0x11 add, 5→0x1E add-with-carry, 6→0x1F subtract, 7→0x20 subtract-with-borrow, 8→0x18 jump, 9→0x14 conditional jump, A→0x12 input, C→0x19 add-from-memory, E→0x15 output.
- R4: Opcodes 3, B, D and F map to 0x00. The cycle after decode is therefore a fetch (`ir_en`=1, `phase`=00), and no execute or increment word appears.
- R5: `ir_cond` selects the jump condition: 00 zero flag set, 01 zero flag clear, 10 carry set, 11 carry clear. When a conditional microword (bit 27 set) sees a true condition, `pc_en` is 1 and the next word is fetch.
- R6: When a conditional microword sees a false condition, `pc_en` is 0 and the next word is its link, the increment word.
- R7: On microwords with bit 27 clear, `pc_en` equals microword bit 2. Only the increment word and the unconditional jump word (0x18, which links to 0x00) set it.
- R8: Microword bits 15-14 set `alu_cin`: 00 gives 0, 01 gives 1, 10 gives the inverted carry flag, 11 gives the carry flag. Add-with-carry uses mode 11, subtract-with-borrow uses mode 10, and subtract uses mode 01.
- R9: `mem_wr` is high exactly when microword bit 16 is set. Only the second execute word of the output routine sets it.
- R10: The remaining outputs follow fixed microword bits:
  - bits 0 to 7: accumulator enable and reset, PC enable and reset, IR enable and reset, status enable and reset
  - bits 8, 9 and 10: operand A select, operand B select and address select
  - bits 13-11: ALU function
  - bits 29-28: always 0
- R11: Execute routines run for a fixed number of words before the increment word: one word for the single-cycle ops, two for input, and three for output and for add-from-memory. Each routine uses its own select pattern (see the notes for the per-word pattern).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of the microword register |
| ir_opcode | input | 4 | Instruction register bits 15-12 |
| ir_cond | input | 2 | Instruction register bits 11-10, jump condition select |
| flag_c | input | 1 | Carry flag from the status register |
| flag_z | input | 1 | Zero flag from the status register |
| acc_en | output | 1 | Accumulator load enable |
| acc_rst | output | 1 | Accumulator clear |
| pc_en | output | 1 | Program counter load enable (condition-qualified) |
| pc_rst | output | 1 | Program counter clear |
| ir_en | output | 1 | Instruction register load enable |
| ir_rst | output | 1 | Instruction register clear |
| st_en | output | 1 | Status flag register load enable |
| st_rst | output | 1 | Status flag register clear |
| opa_sel | output | 1 | ALU operand A multiplexer select |
| opb_sel | output | 1 | ALU operand B multiplexer select |
| addr_sel | output | 1 | Memory address multiplexer select |
| alu_fn | output | 3 | ALU function code |
| alu_cin | output | 1 | ALU carry-in |
| mem_wr | output | 1 | Memory write strobe |
| phase | output | 2 | Phase code of the current microword |

## Verification
Most errors in this block appear at the ports within one cycle. A corrupted microword register or a wrong next-address choice shows up on the very next edge: the phase code breaks the fetch, decode, execute, increment order, or `ir_en` appears outside fetch. A wrong dispatch entry produces an ALU function or a select pattern that does not belong to the opcode, one cycle after decode. A reversed condition encoding flips `pc_en` in the same cycle. It also puts an increment word where a fetch word should follow, or the reverse, on the next edge.

Per-word select patterns for R11:
- input: address select, then address select plus accumulator enable
- output: three address-select words, with the write on the second
- add-from-memory: address select, then address select plus IR enable, then operand B plus accumulator enable with ALU function 001

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  localparam int UA_W   = 8;
  localparam int OPC_W  = 4;
  localparam int CSEL_W = 2;
  localparam int ALU_W  = 3;
  localparam int CTL_W  = 11;
  localparam int MAP_N  = 1 << OPC_W;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'b00,
    PH_DECODE = 2'b01,
    PH_EXEC   = 2'b10,
    PH_INCR   = 2'b11
  } phase_e;

  typedef enum logic [1:0] {
    CI_ZERO   = 2'b00,
    CI_ONE    = 2'b01,
    CI_NCARRY = 2'b10,
    CI_CARRY  = 2'b11
  } cin_mode_e;

  // 30-bit control word, most significant member first
  typedef struct packed {
    logic [1:0]      spare;
    logic            cond;
    phase_e          phase;
    logic [UA_W-1:0] link;
    logic            wr;
    cin_mode_e       cin;
    logic [ALU_W-1:0] alu;
    logic            addr_sel;
    logic            opb_sel;
    logic            opa_sel;
    logic            st_rst;
    logic            st_en;
    logic            ir_rst;
    logic            ir_en;
    logic            pc_rst;
    logic            pc_en;
    logic            acc_rst;
    logic            acc_en;
  } uword_t;

  // fixed microstore anchors
  localparam logic [UA_W-1:0] UA_FETCH  = 8'h00;
  localparam logic [UA_W-1:0] UA_DECODE = 8'h01;
  localparam logic [UA_W-1:0] UA_INCR   = 8'h02;

  // low control group, bit 0 upward: acc_en acc_rst pc_en pc_rst ir_en
  // ir_rst st_en st_rst opa_sel opb_sel addr_sel
  localparam logic [CTL_W-1:0] C_NONE  = 11'h000;
  localparam logic [CTL_W-1:0] C_IRLD  = 11'h010;
  localparam logic [CTL_W-1:0] C_STEP  = 11'h104;
  localparam logic [CTL_W-1:0] C_ACC   = 11'h001;
  localparam logic [CTL_W-1:0] C_ARITH = 11'h241;
  localparam logic [CTL_W-1:0] C_MEM   = 11'h400;
  localparam logic [CTL_W-1:0] C_MEMLD = 11'h401;
  localparam logic [CTL_W-1:0] C_MEMIR = 11'h410;
  localparam logic [CTL_W-1:0] C_BACC  = 11'h201;
  localparam logic [CTL_W-1:0] C_PCLD  = 11'h004;

  function automatic uword_t mk_word(
    input logic [UA_W-1:0]  link,
    input phase_e           ph,
    input logic             cnd,
    input logic             wr,
    input cin_mode_e        ci,
    input logic [ALU_W-1:0] alu,
    input logic [CTL_W-1:0] ctl
  );
    uword_t r;
    r       = '0;
    r.link  = link;
    r.phase = ph;
    r.cond  = cnd;
    r.wr    = wr;
    r.cin   = ci;
    r.alu   = alu;
    {r.addr_sel, r.opb_sel, r.opa_sel, r.st_rst, r.st_en, r.ir_rst,
     r.ir_en, r.pc_rst, r.pc_en, r.acc_rst, r.acc_en} = ctl;
    return r;
  endfunction

endpackage

// File: rtl/ucode_opmap.sv
module ucode_opmap
  import ucode_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output logic [UA_W-1:0]  start_ua
);

  always_comb begin
    case (opcode)
      4'h0:    start_ua = 8'h10;
      4'h1:    start_ua = 8'h1C;
      4'h2:    start_ua = 8'h1D;
      4'h4:    start_ua = 8'h11;
      4'h5:    start_ua = 8'h1E;
      4'h6:    start_ua = 8'h1F;
      4'h7:    start_ua = 8'h20;
      4'h8:    start_ua = 8'h18;
      4'h9:    start_ua = 8'h14;
      4'hA:    start_ua = 8'h12;
      4'hC:    start_ua = 8'h19;
      4'hE:    start_ua = 8'h15;
      default: start_ua = UA_FETCH;
    endcase
  end

endmodule

// File: rtl/ucode_store.sv
module ucode_store
  import ucode_pkg::*;
(
  input  logic [UA_W-1:0] ua,
  output uword_t          word
);

  always_comb begin
    case (ua)
      // common sequence
      8'h00: word = mk_word(UA_DECODE, PH_FETCH,  1'b0, 1'b0, CI_ZERO,   3'b000, C_IRLD);
      8'h01: word = mk_word(UA_FETCH,  PH_DECODE, 1'b0, 1'b0, CI_ZERO,   3'b000, C_NONE);
      8'h02: word = mk_word(UA_FETCH,  PH_INCR,   1'b0, 1'b0, CI_ONE,    3'b000, C_STEP);
      // immediate load and add
      8'h10: word = mk_word(UA_INCR,   PH_EXEC,   1'b0, 1'b0, CI_ONE,    3'b011, C_ACC);
      8'h11: word = mk_word(UA_INCR,   PH_EXEC,   1'b0, 1'b0, CI_ZERO,   3'b001, C_ARITH);
      // input from memory: two words
      8'h12: word = mk_word(8'h13,     PH_EXEC,   1'b0, 1'b0, CI_ZERO,   3'b000, C_MEM);
      8'h13: word = mk_word(UA_INCR,   PH_EXEC,   1'b0, 1'b0, CI_ZERO,   3'b000, C_MEMLD);
      // conditional jump
      8'h14: word = mk_word(UA_INCR,   PH_EXEC,   1'b1, 1'b0, CI_ONE,    3'b011, C_NONE);
      // output to memory: three words, write in the middle
      8'h15: word = mk_word(8'h16,     PH_EXEC,   1'b0, 1'b0, CI_ZERO,   3'b000, C_MEM);
      8'h16: word = mk_word(8'h17,     PH_EXEC,   1'b0, 1'b1, CI_ZERO,   3'b000, C_MEM);
      8'h17: word = mk_word(UA_INCR,   PH_EXEC,   1'b0, 1'b0, CI_ZERO,   3'b000, C_MEM);
      // unconditional jump, skips increment
      8'h18: word = mk_word(UA_FETCH,  PH_EXEC,   1'b0, 1'b0, CI_ONE,    3'b011, C_PCLD);
      // add from memory: three words, IR reused as data buffer
      8'h19: word = mk_word(8'h1A,     PH_EXEC,   1'b0, 1'b0, CI_ZERO,   3'b000, C_MEM);
      8'h1A: word = mk_word(8'h1B,     PH_EXEC,   1'b0, 1'b0, CI_ZERO,   3'b000, C_MEMIR);
      8'h1B: word = mk_word(UA_INCR,   PH_EXEC,   1'b0, 1'b0, CI_ZERO,   3'b001, C_BACC);
      // logic and carry-chain arithmetic on immediates
      8'h1C: word = mk_word(UA_INCR,   PH_EXEC,   1'b0, 1'b0, CI_ZERO,   3'b110, C_ARITH);
      8'h1D: word = mk_word(UA_INCR,   PH_EXEC,   1'b0, 1'b0, CI_ZERO,   3'b101, C_ARITH);
      8'h1E: word = mk_word(UA_INCR,   PH_EXEC,   1'b0, 1'b0, CI_CARRY,  3'b001, C_ARITH);
      8'h1F: word = mk_word(UA_INCR,   PH_EXEC,   1'b0, 1'b0, CI_ONE,    3'b010, C_ARITH);
      8'h20: word = mk_word(UA_INCR,   PH_EXEC,   1'b0, 1'b0, CI_NCARRY, 3'b010, C_ARITH);
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/ucode_cond.sv
module ucode_cond
  import ucode_pkg::*;
(
  input  logic [CSEL_W-1:0] sel,
  input  logic              flag_c,
  input  logic              flag_z,
  output logic              holds
);

  always_comb begin
    case (sel)
      2'b00:   holds = flag_z;
      2'b01:   holds = ~flag_z;
      2'b10:   holds = flag_c;
      default: holds = ~flag_c;
    endcase
  end

endmodule

// File: rtl/ucode_nextsel.sv
module ucode_nextsel
  import ucode_pkg::*;
(
  input  phase_e          cur_phase,
  input  logic            cur_cond,
  input  logic [UA_W-1:0] cur_link,
  input  logic            cur_pc_en,
  input  cin_mode_e       cur_cin,
  input  logic [UA_W-1:0] map_ua,
  input  logic            cond_ok,
  input  logic            flag_c,
  output logic [UA_W-1:0] next_ua,
  output logic            pc_en,
  output logic            alu_cin
);

  logic jump_taken;
  assign jump_taken = cur_cond & cond_ok;

  always_comb begin
    if (cur_phase == PH_DECODE)
      next_ua = map_ua;
    else if (jump_taken)
      next_ua = UA_FETCH;
    else
      next_ua = cur_link;
  end

  assign pc_en = cur_cond ? cond_ok : cur_pc_en;

  always_comb begin
    case (cur_cin)
      CI_ZERO:   alu_cin = 1'b0;
      CI_ONE:    alu_cin = 1'b1;
      CI_NCARRY: alu_cin = ~flag_c;
      default:   alu_cin = flag_c;
    endcase
  end

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  ir_opcode,
  input  logic [CSEL_W-1:0] ir_cond,
  input  logic              flag_c,
  input  logic              flag_z,
  output logic              acc_en,
  output logic              acc_rst,
  output logic              pc_en,
  output logic              pc_rst,
  output logic              ir_en,
  output logic              ir_rst,
  output logic              st_en,
  output logic              st_rst,
  output logic              opa_sel,
  output logic              opb_sel,
  output logic              addr_sel,
  output logic [ALU_W-1:0]  alu_fn,
  output logic              alu_cin,
  output logic              mem_wr,
  output logic [1:0]        phase
);

  uword_t          mw_q;
  uword_t          store_word;
  logic [UA_W-1:0] map_ua;
  logic [UA_W-1:0] next_ua;
  logic [UA_W-1:0] ua_q;
  logic            cond_ok;

  ucode_opmap u_map (
    .opcode   (ir_opcode),
    .start_ua (map_ua)
  );

  ucode_cond u_cond (
    .sel    (ir_cond),
    .flag_c (flag_c),
    .flag_z (flag_z),
    .holds  (cond_ok)
  );

  ucode_nextsel u_next (
    .cur_phase (mw_q.phase),
    .cur_cond  (mw_q.cond),
    .cur_link  (mw_q.link),
    .cur_pc_en (mw_q.pc_en),
    .cur_cin   (mw_q.cin),
    .map_ua    (map_ua),
    .cond_ok   (cond_ok),
    .flag_c    (flag_c),
    .next_ua   (next_ua),
    .pc_en     (pc_en),
    .alu_cin   (alu_cin)
  );

  ucode_store u_store (
    .ua   (next_ua),
    .word (store_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mw_q <= '0;
      ua_q <= UA_FETCH;
    end else begin
      mw_q <= store_word;
      ua_q <= next_ua;
    end
  end

  assign acc_en   = mw_q.acc_en;
  assign acc_rst  = mw_q.acc_rst;
  assign pc_rst   = mw_q.pc_rst;
  assign ir_en    = mw_q.ir_en;
  assign ir_rst   = mw_q.ir_rst;
  assign st_en    = mw_q.st_en;
  assign st_rst   = mw_q.st_rst;
  assign opa_sel  = mw_q.opa_sel;
  assign opb_sel  = mw_q.opb_sel;
  assign addr_sel = mw_q.addr_sel;
  assign alu_fn   = mw_q.alu;
  assign mem_wr   = mw_q.wr;
  assign phase    = mw_q.phase;

  // fetch word always hands over to decode
  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_q.phase == PH_FETCH && mw_q.ir_en) |=> (mw_q.phase == PH_DECODE));

  // increment always returns to fetch
  p_incr_to_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_q.phase == PH_INCR) |=> (mw_q.phase == PH_FETCH && mw_q.ir_en));

  // decode dispatches through the opcode table
  p_decode_dispatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_q.phase == PH_DECODE) |=> (ua_q == $past(map_ua)));

  // taken condition skips increment
  p_taken_to_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_q.cond && cond_ok) |=> (mw_q.phase == PH_FETCH));

  // failed condition leaves PC alone and goes to increment
  p_not_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_q.cond && !cond_ok) |-> (!pc_en ##1 (mw_q.phase == PH_INCR)));

  // writes only happen inside execute routines
  p_write_in_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mw_q.phase == PH_EXEC));

  // spare field never set
  p_spare_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_q.spare == 2'b00));

endmodule

// File: tb/sim_ucode_sequencer.sv
module sim_ucode_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ir_opcode = 4'h0;
  logic [1:0] ir_cond = 2'b00;
  logic       flag_c = 1'b0;
  logic       flag_z = 1'b0;
  logic       acc_en, acc_rst, pc_en, pc_rst, ir_en, ir_rst, st_en, st_rst;
  logic       opa_sel, opb_sel, addr_sel, alu_cin, mem_wr;
  logic [2:0] alu_fn;
  logic [1:0] phase;

  int checks = 0;
  int failures = 0;
  logic [29:0] mword = '0;
  int unsigned seed = 32'd1234;

  always #10 clk = ~clk;

  ucode_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode), .ir_cond(ir_cond),
    .flag_c(flag_c), .flag_z(flag_z), .acc_en(acc_en), .acc_rst(acc_rst),
    .pc_en(pc_en), .pc_rst(pc_rst), .ir_en(ir_en), .ir_rst(ir_rst),
    .st_en(st_en), .st_rst(st_rst), .opa_sel(opa_sel), .opb_sel(opb_sel),
    .addr_sel(addr_sel), .alu_fn(alu_fn), .alu_cin(alu_cin),
    .mem_wr(mem_wr), .phase(phase)
  );

  // word packing per R10: {spare, cond, phase, link, wr, cin, alu, ctl11}
  function automatic logic [29:0] w(input logic [7:0] link, input logic [1:0] ph,
      input logic cnd, input logic wr, input logic [1:0] ci,
      input logic [2:0] alu, input logic [10:0] ctl);
    return {2'b00, cnd, ph, link, wr, ci, alu, ctl};
  endfunction

  function automatic logic [29:0] rom(input logic [7:0] a);
    case (a)
      8'h00: return w(8'h01, 2'b00, 0, 0, 2'b00, 3'b000, 11'h010);
      8'h01: return w(8'h00, 2'b01, 0, 0, 2'b00, 3'b000, 11'h000);
      8'h02: return w(8'h00, 2'b11, 0, 0, 2'b01, 3'b000, 11'h104);
      8'h10: return w(8'h02, 2'b10, 0, 0, 2'b01, 3'b011, 11'h001);
      8'h11: return w(8'h02, 2'b10, 0, 0, 2'b00, 3'b001, 11'h241);
      8'h12: return w(8'h13, 2'b10, 0, 0, 2'b00, 3'b000, 11'h400);
      8'h13: return w(8'h02, 2'b10, 0, 0, 2'b00, 3'b000, 11'h401);
      8'h14: return w(8'h02, 2'b10, 1, 0, 2'b01, 3'b011, 11'h000);
      8'h15: return w(8'h16, 2'b10, 0, 0, 2'b00, 3'b000, 11'h400);
      8'h16: return w(8'h17, 2'b10, 0, 1, 2'b00, 3'b000, 11'h400);
      8'h17: return w(8'h02, 2'b10, 0, 0, 2'b00, 3'b000, 11'h400);
      8'h18: return w(8'h00, 2'b10, 0, 0, 2'b01, 3'b011, 11'h004);
      8'h19: return w(8'h1A, 2'b10, 0, 0, 2'b00, 3'b000, 11'h400);
      8'h1A: return w(8'h1B, 2'b10, 0, 0, 2'b00, 3'b000, 11'h410);
      8'h1B: return w(8'h02, 2'b10, 0, 0, 2'b00, 3'b001, 11'h201);
      8'h1C: return w(8'h02, 2'b10, 0, 0, 2'b00, 3'b110, 11'h241);
      8'h1D: return w(8'h02, 2'b10, 0, 0, 2'b00, 3'b101, 11'h241);
      8'h1E: return w(8'h02, 2'b10, 0, 0, 2'b11, 3'b001, 11'h241);
      8'h1F: return w(8'h02, 2'b10, 0, 0, 2'b01, 3'b010, 11'h241);
      8'h20: return w(8'h02, 2'b10, 0, 0, 2'b10, 3'b010, 11'h241);
      default: return '0;
    endcase
  endfunction

  function automatic logic [7:0] dispatch(input logic [3:0] op);
    case (op)
      4'h0: return 8'h10;  4'h1: return 8'h1C;  4'h2: return 8'h1D;
      4'h4: return 8'h11;  4'h5: return 8'h1E;  4'h6: return 8'h1F;
      4'h7: return 8'h20;  4'h8: return 8'h18;  4'h9: return 8'h14;
      4'hA: return 8'h12;  4'hC: return 8'h19;  4'hE: return 8'h15;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic cond_true(input logic [1:0] s, input logic c, input logic z);
    case (s)
      2'b00: return z;
      2'b01: return !z;
      2'b10: return c;
      default: return !c;
    endcase
  endfunction

  function automatic logic exp_cin(input logic [1:0] m, input logic c);
    case (m)
      2'b00: return 1'b0;
      2'b01: return 1'b1;
      2'b10: return !c;
      default: return c;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a negedge: drive, settle, compare, advance model, wait next negedge
  task automatic step(input logic [3:0] op, input logic [1:0] cs, input logic c, input logic z,
                      input string ptag);
    logic ct;
    logic [7:0] nxt;
    ir_opcode = op; ir_cond = cs; flag_c = c; flag_z = z;
    #1;
    ct = cond_true(cs, c, z);
    chk(ptag, {30'd0, phase}, {30'd0, mword[26:25]});
    chk("R10", {21'd0, addr_sel, opb_sel, opa_sel, st_rst, st_en, ir_rst, ir_en,
                pc_rst, acc_rst, acc_en, alu_fn},
               {21'd0, mword[10:3], mword[1:0], mword[13:11]});
    if (mword[27]) chk(ct ? "R5" : "R6", {31'd0, pc_en}, {31'd0, ct});
    else           chk("R7", {31'd0, pc_en}, {31'd0, mword[2]});
    chk("R8", {31'd0, alu_cin}, {31'd0, exp_cin(mword[15:14], c)});
    chk("R9", {31'd0, mem_wr}, {31'd0, mword[16]});
    if (mword[26:25] == 2'b01) nxt = dispatch(op);
    else if (mword[27] && ct)  nxt = 8'h00;
    else                       nxt = mword[24:17];
    mword = rom(nxt);
    @(negedge clk);
  endtask

  function automatic string tag_for_next(input logic [3:0] op);
    if (mword[26:25] == 2'b01) return (dispatch(op) == 8'h00) ? "R4" : "R3";
    if (mword[26:25] == 2'b10) return "R11";
    return "R2";
  endfunction

  // phase check tag describes how the current word was reached
  string ntag = "R1";

  task automatic go(input logic [3:0] op, input logic [1:0] cs, input logic c, input logic z);
    string t;
    t = tag_for_next(op);
    step(op, cs, c, z, ntag);
    ntag = t;
  endtask

  // run one full instruction from a fetch word back to the next fetch
  task automatic run_instr(input logic [3:0] op, input logic [1:0] cs, input logic c, input logic z);
    int n = 0;
    go(op, cs, c, z);
    while (!(mword[26:25] == 2'b00 && mword[4]) && n < 10) begin
      go(op, cs, c, z);
      n++;
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {11'd0, acc_en, acc_rst, pc_en, pc_rst, ir_en, ir_rst, st_en, st_rst,
               opa_sel, opb_sel, addr_sel, alu_fn, alu_cin, mem_wr, phase}, 32'd0);
    rst_n = 1'b1;
    // zero word still held until the first edge
    go(4'h0, 2'b00, 0, 0);
    // R1: first edge gives fetch with IR load
    #1;
    chk("R1", {30'd0, ir_en, phase[0]}, {30'd0, 1'b1, 1'b0});
    ntag = "R1";
    // directed: every opcode, including undefined ones (R4) and multi-word routines (R11)
    for (int op = 0; op < 16; op++) run_instr(op[3:0], 2'b00, 1'b0, 1'b1);
    // directed: each condition, true and false (R5, R6)
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 4; f++)
        run_instr(4'h9, s[1:0], f[1], f[0]);
    // directed: carry-in modes with both carry values (R8)
    for (int c = 0; c < 2; c++) begin
      run_instr(4'h5, 2'b00, c[0], 1'b0);
      run_instr(4'h6, 2'b00, c[0], 1'b0);
      run_instr(4'h7, 2'b00, c[0], 1'b0);
    end
    // random mix, inputs may change every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom(seed);
      seed = seed + 32'd7919;
      go(r[3:0], r[5:4], r[6], r[7]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule